// File: doc/BRIEF.md
# Serial Port Frame-Sync Generator

This block produces the frame-sync strobe for a synchronous serial port that moves data on two data lines at once, sharing one serial clock and one frame-sync line. It runs only when the port is the clock/frame master and is enabled. A down-counter, loaded from a 16-bit divisor field held in the upper half of a 32-bit divisor register, sets the spacing of frames in serial clock cycles. A mode input selects between free-running frames and frames that wait for the buffers of both data channels to be ready.

In buffer-gated mode a transmitting port waits until both transmit buffers hold fresh data, and a receiving port waits until neither receive buffer is full. The counter parks at zero while it waits and fires on the first ready cycle. In free-running mode frames come at the divider rate regardless. A frame that finds a buffer not ready then raises a sticky underflow (transmit) or overflow (receive) flag, which software clears by writing one. Each frame also starts the data path through a shift-start pulse and records which channel leads the frame.

Top module: `fsync_gen`

## Requirements
- R1: After reset, `fs`, `shift_start`, `underflow`, `overflow` and `lead_left` are all 0.
- R2: While `enable` is 0 or `master` is 0, `fs` stays 0 and the counter is held at the divisor. The first frame after both become 1 comes D+1 cycles later, where D is the divisor.
- R3: In free-running mode with D taken from `div_reg[31:16]` (bits 15:0 are ignored), `fs` is a one-cycle pulse repeating every D+1 serial clock cycles. With D = 0 it is high on every cycle.
- R4: With `free_run` = 0 and `is_tx` = 1, a frame is issued only on a cycle where the count is 0 and both `buf_a` and `buf_b` are 1. Otherwise the count holds at 0, and it reloads on the frame.
- R5: With `free_run` = 0 and `is_tx` = 0, a frame is issued only on a cycle where the count is 0 and both `buf_a` and `buf_b` are 0 (neither receive buffer full).
- R6: With `free_run` = 1 the buffer flags have no effect on the timing of `fs`.
- R7: In free-running transmit mode, a frame issued while `buf_a` or `buf_b` is 0 sets `underflow`, which stays set until cleared.
- R8: In free-running receive mode, a frame issued while `buf_a` or `buf_b` is 1 sets `overflow`, which stays set until cleared.
- R9: `err_clr[0]` clears `underflow` and `err_clr[1]` clears `overflow` on the next edge. A new error in the same cycle wins over the clear.
- R10: `shift_start` is high exactly one cycle after each `fs` pulse (default `SHIFT_LAG` = 1).
- R11: At each frame, `lead_left` takes the value of `order_left` (1 = left channel first, 0 = right first) and holds it until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Port enable |
| master | input | 1 | 1 = frame sync generated internally |
| free_run | input | 1 | 1 = frames independent of buffer state |
| is_tx | input | 1 | 1 = transmit, 0 = receive |
| order_left | input | 1 | Channel order: 1 left first, 0 right first |
| div_reg | input | 32 | Divisor register; frame divisor in bits 31:16 |
| buf_a | input | 1 | Channel A buffer full |
| buf_b | input | 1 | Channel B buffer full |
| err_clr | input | 2 | Write-one-to-clear: bit 0 underflow, bit 1 overflow |
| fs | output | 1 | Frame-sync strobe |
| shift_start | output | 1 | Start pulse to the data path |
| underflow | output | 1 | Sticky transmit underflow |
| overflow | output | 1 | Sticky receive overflow |
| lead_left | output | 1 | Channel order latched at the last frame |

## Verification
The generator is driven in free-running mode with divisors 3, 0 and 5, with junk in the low half of the divisor register, which separates period errors and wrong field extraction from pulse-width errors. Gated transmit and receive runs use two buffer flags with different periodic patterns, so a frame given on only one ready channel, or on the wrong polarity, or a failure to park at zero, each shows as a frame at the wrong cycle. Free-running runs with one buffer not ready, followed by clears during quiet and during active error cycles, tell a missing sticky set apart from a wrong clear bit and from a wrong clear priority. Toggling the order input between frames shows whether it is latched only at frames.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

   typedef struct packed {
      logic ready;    // gating condition met
      logic short_b;  // at least one buffer not ready for a frame
   } buf_eval_t;

   localparam int unsigned ERR_UNDER = 0;
   localparam int unsigned ERR_OVER  = 1;
   localparam int unsigned ERR_N     = 2;

endpackage

// File: rtl/fsync_gate.sv
module fsync_gate
   import fsync_pkg::*;
(
   input  logic      free_run,
   input  logic      is_tx,
   input  logic      buf_a,
   input  logic      buf_b,
   output buf_eval_t eval
);

   logic both_full, none_full;

   always_comb begin
      both_full = buf_a & buf_b;
      none_full = ~(buf_a | buf_b);
      if (is_tx) eval.short_b = ~both_full;
      else       eval.short_b = ~none_full;
      eval.ready = free_run | ~eval.short_b;
   end

endmodule

// File: rtl/fsync_divider.sv
module fsync_divider #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   input  logic             ready,
   output logic             fire,
   output logic             fs_q
);

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt;
   logic             at_zero;

   assign at_zero = (cnt == '0);
   assign fire    = run & at_zero & ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         fs_q <= 1'b0;
      end else begin
         fs_q <= fire;
         if (!run)         cnt <= div;
         else if (!at_zero) cnt <= cnt - ONE;
         else if (ready)    cnt <= div;
      end
   end

   // R2: a stopped divider reloads and emits nothing
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!fs_q && cnt == $past(div)));

   // R3: a running divider counts down by one per serial clock
   p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt != '0) |=> (cnt == $past(cnt) - ONE));

   // R4: waiting at zero holds the count
   p_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && at_zero && !ready) |=> (cnt == '0 && !fs_q));

endmodule

// File: rtl/fsync_errflags.sv
module fsync_errflags
   import fsync_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              free_run,
   input  logic              is_tx,
   input  logic              short_b,
   input  logic [ERR_N-1:0]  err_clr,
   output logic [ERR_N-1:0]  flags
);

   logic [ERR_N-1:0] hit;
   logic             bad_frame;

   assign bad_frame       = fire & free_run & short_b;
   assign hit[ERR_UNDER]  = bad_frame & is_tx;
   assign hit[ERR_OVER]   = bad_frame & ~is_tx;

   for (genvar g = 0; g < ERR_N; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flags[g] <= 1'b0;
         else if (hit[g])     flags[g] <= 1'b1;
         else if (err_clr[g]) flags[g] <= 1'b0;
      end

      // R7 R8: a raised flag stays until its clear bit is written
      p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[g] && !err_clr[g]) |=> flags[g]);

      // R9: a clear with no new error drops the flag
      p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (err_clr[g] && !fire) |=> !flags[g]);
   end

endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
   import fsync_pkg::*;
#(
   parameter int unsigned REG_W     = 32,
   parameter int unsigned DIV_W     = 16,
   parameter int unsigned DIV_LSB   = 16,
   parameter int unsigned SHIFT_LAG = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             master,
   input  logic             free_run,
   input  logic             is_tx,
   input  logic             order_left,
   input  logic [REG_W-1:0] div_reg,
   input  logic             buf_a,
   input  logic             buf_b,
   input  logic [1:0]       err_clr,
   output logic             fs,
   output logic             shift_start,
   output logic             underflow,
   output logic             overflow,
   output logic             lead_left
);

   localparam int unsigned DIV_MSB = DIV_LSB + DIV_W - 1;

   if (DIV_MSB >= REG_W) begin : g_bad_field
      $error("divisor field does not fit the register");
   end
   if (SHIFT_LAG > 1) begin : g_bad_lag
      $error("SHIFT_LAG must be 0 or 1");
   end
   if (ERR_N != 2) begin : g_bad_err
      $error("error flag count mismatch");
   end

   localparam logic [REG_W-1:0] FIELD_MASK = ((REG_W'(1) << DIV_W) - REG_W'(1)) << DIV_LSB;

   logic [DIV_W-1:0] div;
   logic             run, fire;
   buf_eval_t        eval;
   logic [ERR_N-1:0] flags;
   logic             unused_bits;

   assign div         = div_reg[DIV_MSB:DIV_LSB];
   assign unused_bits = ^(div_reg & ~FIELD_MASK);
   assign run         = enable & master;

   fsync_gate u_gate (
      .free_run (free_run),
      .is_tx    (is_tx),
      .buf_a    (buf_a),
      .buf_b    (buf_b),
      .eval     (eval)
   );

   fsync_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .div   (div),
      .ready (eval.ready),
      .fire  (fire),
      .fs_q  (fs)
   );

   fsync_errflags u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .free_run (free_run),
      .is_tx    (is_tx),
      .short_b  (eval.short_b),
      .err_clr  (err_clr),
      .flags    (flags)
   );

   assign underflow = flags[ERR_UNDER];
   assign overflow  = flags[ERR_OVER];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lead_left <= 1'b0;
      else if (fire) lead_left <= order_left;
   end

   if (SHIFT_LAG == 1) begin : g_lag
      logic shift_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) shift_q <= 1'b0;
         else        shift_q <= fs;
      end
      assign shift_start = shift_q;

      // R10: the data path starts one cycle after each frame sync
      p_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
         fs |=> shift_start);
   end else begin : g_nolag
      assign shift_start = fs;
   end

   // R4: a gated transmit frame needs both buffers full
   p_gate_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!free_run && is_tx && !(buf_a && buf_b)) |=> !fs);

   // R5: a gated receive frame needs both buffers with room
   p_gate_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!free_run && !is_tx && (buf_a || buf_b)) |=> !fs);

   // R11: channel order changes only at a frame
   p_lead_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !fs |-> (lead_left == $past(lead_left)));

endmodule

// File: tb/fsync_gen_test.sv
module fsync_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0, master = 1'b1, free_run = 1'b1, is_tx = 1'b1;
   logic        order_left = 1'b0;
   logic [31:0] div_reg = {16'd3, 16'hABCD};
   logic        buf_a = 1'b1, buf_b = 1'b1;
   logic [1:0]  err_clr = 2'b00;
   logic        fs, shift_start, underflow, overflow, lead_left;

   always #2.5 clk = ~clk;

   fsync_gen uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .master(master),
      .free_run(free_run), .is_tx(is_tx), .order_left(order_left),
      .div_reg(div_reg), .buf_a(buf_a), .buf_b(buf_b), .err_clr(err_clr),
      .fs(fs), .shift_start(shift_start), .underflow(underflow),
      .overflow(overflow), .lead_left(lead_left)
   );

   typedef struct packed {
      logic f, s, u, o, l;
   } exp_t;

   exp_t  sb_q[$];
   string phase = "R1 reset";
   int    n_chk = 0, n_fail = 0;
   bit    done = 1'b0;

   task automatic check(input bit ok, input string tag, input exp_t act, input exp_t exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got fs/sh/uf/of/ll=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model built from the requirements; pushes one item per edge
   logic [15:0] m_cnt = '0;
   exp_t        m = '0;
   always @(posedge clk) begin
      exp_t nx;
      logic run, gate, shortb, fire;
      nx = m;
      if (!rst_n) begin
         nx = '0;
         m_cnt = '0;
      end else begin
         run    = enable & master;
         shortb = is_tx ? !(buf_a & buf_b) : (buf_a | buf_b);
         gate   = free_run | !shortb;
         fire   = run && m_cnt == 0 && gate;
         if (!run) m_cnt = div_reg[31:16];
         else if (m_cnt != 0) m_cnt = m_cnt - 16'd1;
         else if (gate) m_cnt = div_reg[31:16];
         nx.s = m.f;
         nx.f = fire;
         if (fire && free_run && shortb && is_tx) nx.u = 1'b1;
         else if (err_clr[0]) nx.u = 1'b0;
         if (fire && free_run && shortb && !is_tx) nx.o = 1'b1;
         else if (err_clr[1]) nx.o = 1'b0;
         if (fire) nx.l = order_left;
      end
      m = nx;
      sb_q.push_back(nx);
   end

   // monitor: compares away from the active edge
   always @(negedge clk) begin
      if (sb_q.size() > 0 && !done) begin
         exp_t e, a;
         e = sb_q.pop_front();
         a = '{f: fs, s: shift_start, u: underflow, o: overflow, l: lead_left};
         check(a == e, phase, a, e);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      cyc(3);
      check({fs, shift_start, underflow, overflow, lead_left} == 5'b0, "R1 reset outputs",
            {fs, shift_start, underflow, overflow, lead_left}, '0);
      rst_n = 1'b1;
      cyc(3);
      phase = "R3 free-run D=3";   enable = 1'b1; order_left = 1'b1; cyc(20);
      phase = "R10 shift follows"; cyc(8);
      phase = "R2 enable low";     enable = 1'b0; cyc(8);
      phase = "R2 master low";     enable = 1'b1; master = 1'b0; cyc(8);
      phase = "R2 restart";        master = 1'b1; cyc(10);
      phase = "R3 free-run D=0";   div_reg = {16'd0, 16'h1234}; cyc(6);
      phase = "R3 free-run D=5";   div_reg = {16'd5, 16'hFFFF}; cyc(20);
      phase = "R6 buffers ignored";
      for (int i = 0; i < 24; i++) begin
         buf_a = (i % 3) == 0; buf_b = (i % 4) == 1; cyc(1);
      end
      phase = "R9 clear underflow"; buf_a = 1'b1; buf_b = 1'b1; free_run = 1'b0;
      err_clr = 2'b11; cyc(1); err_clr = 2'b00; cyc(2);
      phase = "R4 gated tx"; div_reg = {16'd2, 16'h0F0F};
      for (int i = 0; i < 60; i++) begin
         buf_a = (i % 7) < 3; buf_b = (i % 5) < 2; order_left = i[1]; cyc(1);
      end
      phase = "R5 gated rx"; is_tx = 1'b0;
      for (int i = 0; i < 60; i++) begin
         buf_a = (i % 6) < 2; buf_b = (i % 4) == 3; order_left = i[2]; cyc(1);
      end
      phase = "R7 underflow sticky"; is_tx = 1'b1; free_run = 1'b1;
      buf_a = 1'b1; buf_b = 1'b0; cyc(8);
      buf_b = 1'b1; cyc(8);
      phase = "R9 clear during error"; buf_b = 1'b0; err_clr = 2'b01;
      for (int i = 0; i < 8; i++) cyc(1);
      err_clr = 2'b00; buf_b = 1'b1;
      phase = "R9 clear underflow"; err_clr = 2'b01; cyc(1); err_clr = 2'b00; cyc(3);
      phase = "R8 overflow sticky"; is_tx = 1'b0; buf_a = 1'b0; buf_b = 1'b1; cyc(8);
      buf_b = 1'b0; cyc(6);
      phase = "R9 wrong clear bit"; err_clr = 2'b01; cyc(2); err_clr = 2'b00; cyc(2);
      phase = "R9 clear overflow"; err_clr = 2'b10; cyc(1); err_clr = 2'b00; cyc(3);
      phase = "R11 order latch"; div_reg = {16'd1, 16'h0};
      for (int i = 0; i < 16; i++) begin order_left = i[0] ^ i[2]; cyc(1); end
      cyc(2);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule